// File: doc/BRIEF.md
# Parallel Printer Byte Receiver

This block is the printer end of a byte-wide parallel link in the classic printer-port style. A host presents eight data lines and drops an active-low strobe to mark them valid. The block answers with two lines of its own: an active-low acknowledge and a busy flag. A downstream consumer asks for a byte by pulsing a request. The block then drops busy, sends a low acknowledge pulse of fixed width, and waits for the host's strobe. On the falling strobe it captures the data, raises busy again and hands the byte over with a one-cycle valid pulse.

The strobe and data pins are asynchronous to the block clock. Both pass through the same synchroniser depth, so the captured byte is sampled in the same cycle as the strobe level that revealed the edge. A strobe edge counts only while the block is waiting after the acknowledge pulse. Edges that arrive while busy is high, or during the acknowledge pulse itself, are discarded.

Top module: `pbyte_rx`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, busy is 1, the active-low acknowledge is 1 (inactive) and valid is 0.
- R2: A request while busy is high makes busy go to 0 and acknowledge go to 0 together, in the cycle after the clock edge that samples the request.
- R3: Acknowledge stays at 0 for exactly ACK_CYCLES clock cycles and then returns to 1. Busy stays at 0 for the whole pulse and after it, until a byte is captured.
- R4: A falling strobe (1 to 0 on the active-low strobe pin) that arrives after the acknowledge pulse has ended captures the data pins. In that cycle valid is 1, the output byte equals the data pins, and busy returns to 1.
- R5: Valid is high for exactly one cycle per captured byte, and the output byte keeps its value until the next capture.
- R6: A falling strobe while busy is 1 is ignored: no valid pulse, and the output byte and busy are unchanged.
- R7: A falling strobe during the acknowledge pulse is ignored. Busy stays 0, and a later falling strobe after the pulse still captures.
- R8: A request during an active transfer (acknowledge pulse or strobe wait) has no effect. It does not restart or lengthen the acknowledge pulse.
- R9: With SYNC_STAGES=2, valid goes high in the third clock cycle after the strobe pin falls, that is, SYNC_STAGES+1 rising edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data_i | input | DATA_W | Data lines from the host |
| host_stb_n_i | input | 1 | Host strobe, active low |
| host_ack_n_o | output | 1 | Acknowledge to the host, active low |
| host_busy_o | output | 1 | Busy flag to the host, high = not ready |
| req_i | input | 1 | Consumer asks for the next byte |
| valid_o | output | 1 | One-cycle pulse marking a captured byte |
| data_o | output | DATA_W | Last captured byte |

## Verification
The hardest situation to reach is a strobe edge landing inside the acknowledge pulse. A well-behaved host never produces it, and it must be told apart from a legal edge a few cycles later. The bench drops the strobe in the first cycle of the acknowledge pulse and releases it before the pulse ends. It then confirms that no byte appears, that busy stays low and that a later legal strobe still captures. Requests repeated during the pulse and the wait check that the pulse width is never restarted.

// File: rtl/pbyte_rx_pkg.sv
package pbyte_rx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACK  = 2'd1,
      ST_WAIT = 2'd2
   } rx_state_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pbyte_rx_sync.sv
module pbyte_rx_sync #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned STAGES     = 2,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb_pin_i,
   input  logic [DATA_W-1:0] data_pin_i,
   output logic              hit_o,
   output logic [DATA_W-1:0] data_s_o
);

   localparam logic IDLE_LVL = ACTIVE_LOW ? 1'b1 : 1'b0;

   logic [STAGES-1:0]  stb_chain_q;
   logic               stb_prev_q;
   logic [DATA_W-1:0]  dat_chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_chain_q <= {STAGES{IDLE_LVL}};
         stb_prev_q  <= IDLE_LVL;
      end else begin
         stb_chain_q <= {stb_chain_q[STAGES-2:0], stb_pin_i};
         stb_prev_q  <= stb_chain_q[STAGES-1];
      end
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_dstage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dat_chain_q[s] <= '0;
         else if (s == 0)
            dat_chain_q[s] <= data_pin_i;
         else
            dat_chain_q[s] <= dat_chain_q[(s == 0) ? 0 : s-1];
      end
   end

   if (ACTIVE_LOW) begin : g_fall
      assign hit_o = stb_prev_q & ~stb_chain_q[STAGES-1];
   end else begin : g_rise
      assign hit_o = ~stb_prev_q & stb_chain_q[STAGES-1];
   end

   assign data_s_o = dat_chain_q[STAGES-1];

endmodule

// File: rtl/pbyte_rx_timer.sv
module pbyte_rx_timer #(
   parameter int unsigned CYCLES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic expire_o
);

   localparam int unsigned CW = pbyte_rx_pkg::cnt_width(CYCLES);
   localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (load_i) begin
         cnt_q    <= LOAD_VAL;
         active_q <= 1'b1;
      end else if (active_q) begin
         if (cnt_q == '0)
            active_q <= 1'b0;
         else
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire_o = active_q && (cnt_q == '0);

   AST_TIMER_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !load_i) |=> !active_q) else $error("timer ran past zero"); // R3

endmodule

// File: rtl/pbyte_rx_ctrl.sv
module pbyte_rx_ctrl
   import pbyte_rx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              expire_i,
   input  logic              hit_i,
   input  logic [DATA_W-1:0] data_s_i,
   output logic              load_o,
   output logic              ack_n_o,
   output logic              busy_o,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o
);

   rx_state_e state_q, state_d;
   logic      take;

   assign load_o = (state_q == ST_IDLE) && req_i;
   assign take   = (state_q == ST_WAIT) && hit_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (req_i)    state_d = ST_ACK;
         ST_ACK:  if (expire_i) state_d = ST_WAIT;
         ST_WAIT: if (hit_i)    state_d = ST_IDLE;
         default:               state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ack_n_o <= 1'b1;
         busy_o  <= 1'b1;
         valid_o <= 1'b0;
         data_o  <= '0;
      end else begin
         state_q <= state_d;
         valid_o <= take;
         if (load_o) begin
            ack_n_o <= 1'b0;
            busy_o  <= 1'b0;
         end
         if ((state_q == ST_ACK) && expire_i)
            ack_n_o <= 1'b1;
         if (take) begin
            busy_o <= 1'b1;
            data_o <= data_s_i;
         end
      end
   end

   AST_ACK_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n_o |-> !busy_o) else $error("ack low while busy"); // R2
   AST_ACK_END_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_n_o) |-> !busy_o) else $error("busy rose during ack"); // R3
   AST_VALID_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> busy_o) else $error("valid without busy"); // R4
   AST_BUSY_RISE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> valid_o) else $error("busy rose without capture"); // R4
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o) else $error("valid longer than one cycle"); // R5
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_o) |-> valid_o) else $error("data changed without capture"); // R5

endmodule

// File: rtl/pbyte_rx.sv
module pbyte_rx #(
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned ACK_CYCLES     = 10,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          STB_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] host_data_i,
   input  logic              host_stb_n_i,
   output logic              host_ack_n_o,
   output logic              host_busy_o,
   input  logic              req_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o
);

   if (DATA_W < 1) begin : g_bad_width
      $error("pbyte_rx: DATA_W must be at least 1");
   end
   if (ACK_CYCLES < 1) begin : g_bad_ack
      $error("pbyte_rx: ACK_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pbyte_rx: SYNC_STAGES must be at least 2");
   end

   logic              hit;
   logic              expire;
   logic              load;
   logic [DATA_W-1:0] data_s;

   pbyte_rx_sync #(
      .DATA_W     (DATA_W),
      .STAGES     (SYNC_STAGES),
      .ACTIVE_LOW (STB_ACTIVE_LOW)
   ) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .stb_pin_i  (host_stb_n_i),
      .data_pin_i (host_data_i),
      .hit_o      (hit),
      .data_s_o   (data_s)
   );

   pbyte_rx_timer #(
      .CYCLES   (ACK_CYCLES)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .expire_o (expire)
   );

   pbyte_rx_ctrl #(
      .DATA_W   (DATA_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_i),
      .expire_i (expire),
      .hit_i    (hit),
      .data_s_i (data_s),
      .load_o   (load),
      .ack_n_o  (host_ack_n_o),
      .busy_o   (host_busy_o),
      .valid_o  (valid_o),
      .data_o   (data_o)
   );

endmodule

// File: tb/pbyte_rx_tb.sv
module pbyte_rx_tb;

   localparam int ACK = 10;
   localparam int NV  = 6;
   localparam logic [7:0] VEC_DATA [NV] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h5A};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] host_data = 8'h00;
   logic       stb_n = 1'b1;
   logic       req = 1'b0;
   logic       ack_n, busy, valid;
   logic [7:0] dout;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pbyte_rx #(.DATA_W(8), .ACK_CYCLES(ACK), .SYNC_STAGES(2), .STB_ACTIVE_LOW(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_data_i(host_data), .host_stb_n_i(stb_n),
      .host_ack_n_o(ack_n), .host_busy_o(busy), .req_i(req),
      .valid_o(valid), .data_o(dout));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // pulse req, then measure ack width; returns measured low cycles
   task automatic start_req(input bit hold_req, output int width);
      @(negedge clk); req = 1'b1;
      @(negedge clk); if (!hold_req) req = 1'b0;
      check(ack_n == 1'b0 && busy == 1'b0, "R2 ack/busy after req", {ack_n, busy}, 0);
      width = 0;
      for (int i = 0; i < 4*ACK && ack_n == 1'b0; i++) begin
         width++;
         if (busy !== 1'b0) check(1'b0, "R3 busy during ack", busy, 0);
         @(negedge clk);
      end
      req = 1'b0;
   endtask

   task automatic strobe_capture(input logic [7:0] b);
      host_data = b;
      stb_n = 1'b0;
      @(negedge clk);
      check(valid == 1'b0, "R9 no valid after 1 edge", valid, 0);
      @(negedge clk);
      check(valid == 1'b0, "R9 no valid after 2 edges", valid, 0);
      @(negedge clk);
      check(valid == 1'b1, "R9/R4 valid after 3 edges", valid, 1);
      check(dout == b, "R4 captured byte", dout, b);
      check(busy == 1'b1, "R4 busy back high", busy, 1);
      @(negedge clk);
      check(valid == 1'b0, "R5 valid one cycle", valid, 0);
      check(dout == b, "R5 byte held", dout, b);
      stb_n = 1'b1;
      host_data = ~b;
      repeat (3) @(negedge clk);
      check(dout == b, "R5 byte held after pins change", dout, b);
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      int w;
      bit seen;
      // R1 reset state
      repeat (3) @(negedge clk);
      check(busy == 1'b1 && ack_n == 1'b1 && valid == 1'b0, "R1 during reset", {busy, ack_n, valid}, 3'b110);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b1 && ack_n == 1'b1 && valid == 1'b0, "R1 after reset", {busy, ack_n, valid}, 3'b110);

      // vector walk: R2 R3 R4 R5 R9
      for (int v = 0; v < NV; v++) begin
         start_req(1'b0, w);
         check(w == ACK, "R3 ack width", w, ACK);
         check(ack_n == 1'b1 && busy == 1'b0, "R3 ack high busy low after pulse", {ack_n, busy}, 2'b10);
         repeat (v) @(negedge clk);
         strobe_capture(VEC_DATA[v]);
      end

      // R6: strobe while busy high
      host_data = 8'h77; stb_n = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < 6; i++) begin @(negedge clk); if (valid) seen = 1'b1; end
      stb_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!seen, "R6 no valid while busy", seen, 0);
      check(dout == VEC_DATA[NV-1], "R6 byte unchanged", dout, VEC_DATA[NV-1]);
      check(busy == 1'b1, "R6 busy unchanged", busy, 1);

      // R7: strobe during ack pulse
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
      host_data = 8'hC3; stb_n = 1'b0;
      seen = 1'b0;
      repeat (4) begin @(negedge clk); if (valid) seen = 1'b1; end
      stb_n = 1'b1;
      repeat (ACK + 4) begin @(negedge clk); if (valid) seen = 1'b1; end
      check(!seen, "R7 no valid for strobe in ack", seen, 0);
      check(busy == 1'b0 && ack_n == 1'b1, "R7 still waiting", {busy, ack_n}, 2'b01);
      check(dout == VEC_DATA[NV-1], "R7 byte unchanged", dout, VEC_DATA[NV-1]);
      strobe_capture(8'h96);

      // R8: request held through ack, and repeated during wait
      start_req(1'b1, w);
      check(w == ACK, "R8 held req does not stretch ack", w, ACK);
      req = 1'b1;
      repeat (3) @(negedge clk);
      check(ack_n == 1'b1 && busy == 1'b0, "R8 req in wait ignored", {ack_n, busy}, 2'b10);
      req = 1'b0;
      strobe_capture(8'h2E);

      done = 1'b1;
      summary();
   end

endmodule